// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block collects level interrupt lines in groups ("banks") of `LINES` lines each and presents them to a processor through a small synchronous register port. Every bank has five registers at fixed offsets: a pending word, an enable word, a read-only view of the pending lines that are enabled, a resend word that keeps lines pending, and an input sense mask. The bank register blocks repeat at a stride of 0x28 bytes, so bank `m` starts at byte address `m*0x28`.

Software clears a pending line by writing a one to its bit in the pending word. Each bank raises its own request output, one cycle after the condition arises, whenever any enabled line is pending. Next to the request it gives the index of the highest-numbered pending enabled line, so the handler can go straight to the most significant source.

Top module: `icu_ctrl`

## Requirements
- R1: After reset every pending, enable and resend word reads 0, every sense mask word reads all ones, and all request, valid and index outputs are 0.
- R2: Within bank `m`, whose base is `m*0x28`, pending is at offset 0x00, enable at 0x08, enabled view at 0x10, resend at 0x18 and sense mask at 0x20. Enable, resend and mask read back what was last written.
- R3: A pending bit becomes 1 at the clock edge where its raw input is high and its sense mask bit is 1. A raw input whose mask bit is 0 does not set its pending bit.
- R4: Writing a word to the pending register clears each pending bit whose written bit is 1 and leaves bits written as 0 unchanged.
- R5: When a pending bit is set by its raw input or by resend at the same edge as a write clears it, the bit stays 1.
- R6: The enabled view at offset 0x10 reads the bitwise AND of pending and enable; writes to it change nothing.
- R7: While a resend bit is 1, its pending bit is set at every edge.
- R8: A bank's request output is the OR of its enabled view bits as they stood before the previous clock edge.
- R9: A bank's valid output equals its request output, and its index output gives the position of the highest enabled view bit as it stood before the previous edge; with nothing valid the index is 0.
- R10: Reads of any address that is not one of the five registers of an existing bank (including unaligned offsets inside a bank and addresses past the last bank) return 0, and writes to them change no register.
- R11: The start-up sequence of writing 0 to enable, all ones to pending and mask, and 0 to resend in every bank leaves every bank with nothing pending, nothing enabled and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Read data for `bus_addr`, combinational |
| raw_irq | input | NUM_MOD*LINES | Raw level inputs, bank `m` on bits `m*LINES +: LINES` |
| irq_req | output | NUM_MOD | Registered request, one bit per bank |
| irq_vld | output | NUM_MOD | Registered valid flag for the index of each bank |
| irq_idx | output | NUM_MOD*IDX_W | Registered index of the highest enabled pending line, bank `m` on bits `m*IDX_W +: IDX_W` |

## Verification
The bench builds the block with three banks of 32 lines and an 8-bit address, so the last bank ends at 0x77 and the range 0x78 to 0xFF past it is reachable as unmapped space, together with the unaligned offsets inside each bank. With 32 lines the index reaches its top value of 31, which the resend and random phases drive, and three banks let a write to one bank be checked for leaving its neighbours alone.

// File: rtl/icu_pkg.sv
package icu_pkg;

    // Byte spacing of one bank's register block; software depends on it.
    localparam int BANK_STRIDE = 40;

    localparam logic [5:0] OFF_PEND = 6'h00;
    localparam logic [5:0] OFF_EN   = 6'h08;
    localparam logic [5:0] OFF_VIEW = 6'h10;
    localparam logic [5:0] OFF_RES  = 6'h18;
    localparam logic [5:0] OFF_MASK = 6'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_EN,
        SEL_VIEW,
        SEL_RES,
        SEL_MASK
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } bank_sel_t;

    function automatic reg_sel_e offset_to_sel(input logic [5:0] off);
        case (off)
            OFF_PEND: return SEL_PEND;
            OFF_EN:   return SEL_EN;
            OFF_VIEW: return SEL_VIEW;
            OFF_RES:  return SEL_RES;
            OFF_MASK: return SEL_MASK;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/icu_decode.sv
module icu_decode
    import icu_pkg::*;
#(
    parameter int NUM_MOD = 3,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0]             addr,
    output bank_sel_t [NUM_MOD-1:0]       sel
);

    logic [31:0] addr32;
    assign addr32 = 32'(addr);

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_bank
        localparam logic [31:0] BASE = 32'(m * BANK_STRIDE);
        localparam logic [31:0] LIMIT = 32'((m + 1) * BANK_STRIDE);
        logic       in_rng;
        logic [5:0] off;
        reg_sel_e   kind;

        assign in_rng = (addr32 >= BASE) && (addr32 < LIMIT);
        assign off    = 6'(addr32 - BASE);
        assign kind   = offset_to_sel(off);

        always_comb begin
            sel[m].hit = in_rng && (kind != SEL_NONE);
            sel[m].sel = in_rng ? kind : SEL_NONE;
        end
    end

endmodule

// File: rtl/icu_msb_enc.sv
module icu_msb_enc #(
    parameter int WIDTH = 32,
    parameter int IDX_W = 5
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scanning upward with the last match winning yields the top set bit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/icu_bank.sv
module icu_bank
    import icu_pkg::*;
#(
    parameter int LINES = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_sel_t        sel,
    input  logic             we,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] rdata,
    output logic             req,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);

    logic [LINES-1:0] pend, en, res, msk;
    logic [LINES-1:0] act, set_vec, clr_vec;
    logic             found_c;
    logic [IDX_W-1:0] idx_c;
    logic             wr_hit;

    assign wr_hit  = we && sel.hit;
    assign act     = pend & en;
    assign set_vec = (raw & msk) | res;
    assign clr_vec = (wr_hit && sel.sel == SEL_PEND) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            en   <= '0;
            res  <= '0;
            msk  <= '1;
        end else begin
            pend <= (pend & ~clr_vec) | set_vec;
            if (wr_hit && sel.sel == SEL_EN)   en  <= wdata;
            if (wr_hit && sel.sel == SEL_RES)  res <= wdata;
            if (wr_hit && sel.sel == SEL_MASK) msk <= wdata;
        end
    end

    always_comb begin
        case (sel.sel)
            SEL_PEND: rdata = pend;
            SEL_EN:   rdata = en;
            SEL_VIEW: rdata = act;
            SEL_RES:  rdata = res;
            SEL_MASK: rdata = msk;
            default:  rdata = '0;
        endcase
    end

    icu_msb_enc #(.WIDTH(LINES), .IDX_W(IDX_W)) u_enc (
        .vec   (act),
        .found (found_c),
        .idx   (idx_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            vld <= 1'b0;
            idx <= '0;
        end else begin
            req <= |act;
            vld <= found_c;
            idx <= idx_c;
        end
    end

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((pend & $past(clr_vec) & ~$past(set_vec)) == '0));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (($past(pend) & ~pend & ~$past(clr_vec)) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((pend & $past(set_vec)) == $past(set_vec)));

    // R9
    idx_hit_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> ((($past(act) >> idx) & LINES'(1)) != '0));

    // R9
    idx_top_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> ((($past(act) >> idx) >> 1) == '0));

endmodule

// File: rtl/icu_ctrl.sv
module icu_ctrl
    import icu_pkg::*;
#(
    parameter int NUM_MOD = 3,
    parameter int LINES   = 32,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = $clog2(LINES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [LINES-1:0]         bus_wdata,
    output logic [LINES-1:0]         bus_rdata,
    input  logic [NUM_MOD*LINES-1:0] raw_irq,
    output logic [NUM_MOD-1:0]       irq_req,
    output logic [NUM_MOD-1:0]       irq_vld,
    output logic [NUM_MOD*IDX_W-1:0] irq_idx
);

    bank_sel_t [NUM_MOD-1:0] sel;
    logic [LINES-1:0]        bank_rd [NUM_MOD];
    logic [NUM_MOD-1:0]      hits;

    icu_decode #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_bank
        assign hits[m] = sel[m].hit;
        icu_bank #(.LINES(LINES), .IDX_W(IDX_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .sel   (sel[m]),
            .we    (bus_we),
            .wdata (bus_wdata),
            .raw   (raw_irq[m*LINES +: LINES]),
            .rdata (bank_rd[m]),
            .req   (irq_req[m]),
            .vld   (irq_vld[m]),
            .idx   (irq_idx[m*IDX_W +: IDX_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int m = 0; m < NUM_MOD; m++) bus_rdata |= bank_rd[m];
    end

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (hits == '0) |-> (bus_rdata == '0));

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> $onehot0(hits));

endmodule

// File: tb/icu_ctrl_test.sv
module icu_ctrl_test;
    localparam int NM = 3;
    localparam int LN = 32;
    localparam int AW = 8;
    localparam int IW = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [LN-1:0]     bus_wdata = '0;
    logic [LN-1:0]     bus_rdata;
    logic [NM*LN-1:0]  raw_irq = '0;
    logic [NM-1:0]     irq_req, irq_vld;
    logic [NM*IW-1:0]  irq_idx;

    icu_ctrl #(.NUM_MOD(NM), .LINES(LN), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_irq(raw_irq),
        .irq_req(irq_req), .irq_vld(irq_vld), .irq_idx(irq_idx)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [LN-1:0]    m_pend [NM];
    logic [LN-1:0]    m_en   [NM];
    logic [LN-1:0]    m_res  [NM];
    logic [LN-1:0]    m_msk  [NM];
    logic [NM-1:0]    m_req, m_vld;
    logic [NM*IW-1:0] m_idx;
    logic [NM*LN-1:0] raw_drv = '0;

    function automatic int top_bit(input logic [LN-1:0] v);
        int r = 0;
        for (int i = 0; i < LN; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [LN-1:0] model_read(input int a);
        int m = a / 40;
        int off = a % 40;
        if (m >= NM) return '0;
        case (off)
            0:  return m_pend[m];
            8:  return m_en[m];
            16: return m_pend[m] & m_en[m];
            24: return m_res[m];
            32: return m_msk[m];
            default: return '0;
        endcase
    endfunction

    task automatic model_reset();
        for (int m = 0; m < NM; m++) begin
            m_pend[m] = '0; m_en[m] = '0; m_res[m] = '0; m_msk[m] = '1;
        end
        m_req = '0; m_vld = '0; m_idx = '0;
    endtask

    task automatic model_edge(input bit we, input int a, input logic [LN-1:0] wd);
        int wm = a / 40;
        int off = a % 40;
        for (int m = 0; m < NM; m++) begin
            logic [LN-1:0] act, clr, setv;
            act = m_pend[m] & m_en[m];
            m_req[m] = |act;
            m_vld[m] = |act;
            m_idx[m*IW +: IW] = (|act) ? IW'(top_bit(act)) : '0;
            setv = (raw_drv[m*LN +: LN] & m_msk[m]) | m_res[m];
            clr = (we && wm == m && off == 0) ? wd : '0;
            m_pend[m] = (m_pend[m] & ~clr) | setv;
            if (we && wm == m) begin
                if (off == 8)  m_en[m]  = wd;
                if (off == 24) m_res[m] = wd;
                if (off == 32) m_msk[m] = wd;
            end
        end
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive, compare pre-edge state, advance model
    task automatic step(input bit we, input int a, input logic [LN-1:0] wd, input string tag);
        @(negedge clk);
        bus_we = we; bus_addr = AW'(a); bus_wdata = wd; raw_irq = raw_drv;
        #1;
        if (!we) check(tag, 64'(bus_rdata), 64'(model_read(a)));
        check("R8", 64'(irq_req), 64'(m_req));
        check("R9", 64'({irq_vld, irq_idx}), 64'({m_vld, m_idx}));
        @(posedge clk);
        model_edge(we, a, wd);
    endtask

    task automatic rd(input int a, input string tag);
        step(1'b0, a, '0, tag);
    endtask

    task automatic wr(input int a, input logic [LN-1:0] d, input string tag);
        step(1'b1, a, d, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset values
        for (int m = 0; m < NM; m++) begin
            rd(m*40 + 0,  "R1");
            rd(m*40 + 8,  "R1");
            rd(m*40 + 16, "R1");
            rd(m*40 + 24, "R1");
            rd(m*40 + 32, "R1");
        end

        // R11 start-up sequence
        for (int m = 0; m < NM; m++) begin
            wr(m*40 + 8,  '0, "R11");
            wr(m*40 + 0,  '1, "R11");
            wr(m*40 + 32, '1, "R11");
            wr(m*40 + 24, '0, "R11");
        end
        for (int m = 0; m < NM; m++) begin
            rd(m*40 + 0,  "R11");
            rd(m*40 + 8,  "R11");
            rd(m*40 + 16, "R11");
        end

        // R2 map and readback
        wr(40 + 8, 32'hA5A5_0F0F, "R2");
        rd(40 + 8, "R2");
        rd(8, "R2");
        wr(80 + 32, 32'hFFFF_0000, "R2");
        rd(80 + 32, "R2");
        wr(80 + 32, '1, "R2");
        wr(40 + 8, '0, "R2");

        // R3 capture and sense mask
        raw_drv[5] = 1'b1;
        rd(0, "R3");
        raw_drv = '0;
        rd(0, "R3");
        wr(32, ~(32'h1 << 7), "R3");
        raw_drv[7] = 1'b1;
        rd(0, "R3");
        raw_drv = '0;
        rd(0, "R3");
        wr(32, '1, "R3");

        // R4 write-one-to-clear
        wr(0, '0, "R4");
        rd(0, "R4");
        wr(0, 32'h1 << 5, "R4");
        rd(0, "R4");

        // R5 set beats clear
        raw_drv[9] = 1'b1;
        rd(0, "R5");
        wr(0, 32'h1 << 9, "R5");
        raw_drv = '0;
        rd(0, "R5");
        wr(0, '1, "R5");
        rd(0, "R5");

        // R6 / R8 / R9 enabled view, request, index
        raw_drv[3] = 1'b1; raw_drv[20] = 1'b1;
        rd(16, "R6");
        raw_drv = '0;
        wr(8, (32'h1 << 3) | (32'h1 << 20) | (32'h1 << 25), "R6");
        rd(16, "R6");
        rd(16, "R6");
        wr(16, '1, "R6");
        rd(16, "R6");
        rd(0, "R6");
        wr(0, 32'h1 << 20, "R9");
        rd(16, "R9");
        rd(16, "R9");
        wr(0, '1, "R8");
        rd(16, "R8");
        rd(16, "R8");
        wr(8, '0, "R8");

        // R7 resend
        wr(40 + 24, 32'h8000_0000, "R7");
        wr(40 + 8, 32'h8000_0001, "R7");
        rd(40 + 0, "R7");
        wr(40 + 0, '1, "R7");
        rd(40 + 0, "R7");
        rd(40 + 16, "R7");
        wr(40 + 24, '0, "R7");
        wr(40 + 0, '1, "R7");
        rd(40 + 0, "R7");
        rd(40 + 0, "R7");
        wr(40 + 8, '0, "R7");

        // R10 unmapped space
        wr(8'h04, '1, "R10");
        wr(8'h7C, '1, "R10");
        wr(8'hFF, '1, "R10");
        wr(40 + 36, '1, "R10");
        rd(8'h04, "R10");
        rd(40 + 36, "R10");
        rd(8'h78, "R10");
        rd(8'hFF, "R10");
        for (int m = 0; m < NM; m++) begin
            rd(m*40 + 0,  "R10");
            rd(m*40 + 8,  "R10");
            rd(m*40 + 24, "R10");
            rd(m*40 + 32, "R10");
        end

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int m, a, pick;
            bit we;
            logic [LN-1:0] d;
            for (int k = 0; k < NM; k++)
                raw_drv[k*LN +: LN] = $urandom & $urandom & $urandom;
            m = $urandom_range(0, 3);
            pick = $urandom_range(0, 6);
            case (pick)
                0: a = 0;
                1: a = 8;
                2: a = 16;
                3: a = 24;
                4: a = 32;
                5: a = 0;
                default: a = $urandom_range(0, 39);
            endcase
            a = m*40 + a;
            if (a > 255) a = 255;
            we = ($urandom_range(0, 2) == 0);
            d = $urandom;
            if (a % 40 == 24) d = d & $urandom & $urandom & $urandom;
            if (a % 40 == 0 && $urandom_range(0, 1) == 1) d = '1;
            step(we, a, d, "R2");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule